// File: doc/BRIEF.md
# Camera Packet Header Event Monitor

This block sits behind the header decoder of a serial camera receiver and watches every decoded packet header. It tracks, separately for each of sixteen virtual channels, whether a frame is open. It also tracks whether any long-packet payload inside that frame failed its CRC. From this it produces single-cycle error events, one bit per channel: frame-sync errors, frame-data errors and data-type errors.

The block has two input strobes. A header strobe carries the channel, a 6-bit data type and a 16-bit word count, or the payload of a short packet. A packet-end strobe marks the end of a long packet and reports whether its payload CRC failed.

The block also keeps the most recent generic short packet as one capture word. For each channel it holds the data type of the latest video long packet. Downstream status logic samples these outputs directly.

Top module: `pkt_hdr_monitor`

## Requirements
- R1: After reset every event vector, the capture word and every per-channel video data type read zero.
- R2: A frame-end header (data type 0x01) on a channel with no open frame raises that channel's bit of `sync_err_evt`. A frame-start header (data type 0x00) opens the frame, and a frame-end on an open frame closes it without a sync error.
- R3: A packet-end strobe with `pkt_end_crc_bad` set, on a channel whose frame is open, marks that frame. The next frame-end on the channel raises its `data_err_evt` bit and clears the mark, so the following frame starts clean.
- R4: A CRC failure reported on a channel with no open frame has no effect on any later frame of that channel.
- R5: A frame-start on a channel whose frame is already open restarts the frame: it raises no event and discards any CRC mark.
- R6: Frame state is independent per channel. Headers and packet ends on one channel never change the events of another.
- R7: A header whose data type has a clear bit in the parameter `SUPPORTED_DT` raises `dtype_err_evt` for the header's channel. Such a header is otherwise ignored: no frame, capture or video-type change. The default set is 0x00-0x03, 0x08-0x0F, 0x12, 0x18-0x1F, 0x22-0x24, 0x28-0x2D and 0x30-0x37.
- R8: A supported header with data type 0x08 to 0x0F loads `gsp_word` as follows: bits 31:24 zero, bits 23:8 the 16-bit payload, bits 7:6 the two low bits of the channel, bits 5:0 the data type. The word holds its value until the next such header.
- R9: A supported header with data type 0x18 or above loads that channel's 6-bit slot of `vc_video_dt` (channel i at bits 6i+5:6i). Supported long types below 0x18 leave the slot unchanged.
- R10: When a CRC-failing packet end and a frame-end header for the same channel arrive in the same cycle, the failure counts in the frame being closed. When a CRC-failing packet end and a frame-start arrive together, the failure is not carried into the new frame.
- R11: Every event is registered. It appears in the cycle after the clock edge that samples its header and lasts exactly one cycle, and at most one event bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header strobe |
| hdr_vc | input | 4 | Virtual channel of the header |
| hdr_dt | input | 6 | Data type of the header |
| hdr_wc | input | 16 | Word count or short-packet payload |
| pkt_end_valid | input | 1 | Long-packet end strobe |
| pkt_end_vc | input | 4 | Channel of the ending packet |
| pkt_end_crc_bad | input | 1 | Payload CRC failed for the ending packet |
| sync_err_evt | output | 16 | Frame-sync error events, one bit per channel |
| data_err_evt | output | 16 | Frame-data error events, one bit per channel |
| dtype_err_evt | output | 16 | Data-type error events, one bit per channel |
| gsp_word | output | 32 | Last captured generic short packet |
| vc_video_dt | output | 96 | Latest video data type, 6 bits per channel |

## Verification
The packet-end strobe and the header strobe are separate inputs, so both can target the same channel in one cycle. The bench provokes this on purpose, in two ways:
- A CRC-failing packet end arrives together with a frame-end. The closing frame must report a data error in the following cycle.
- A CRC-failing packet end arrives together with a frame-start, both on an open frame and on a closed one. The frame-end that follows must report nothing.

A wrong precedence between the two strobes therefore shows up as a missing or extra `data_err_evt` bit.

// File: rtl/pkt_mon_pkg.sv
package pkt_mon_pkg;

    localparam logic [5:0] DT_FRAME_START = 6'h00;
    localparam logic [5:0] DT_FRAME_END   = 6'h01;
    localparam logic [5:0] DT_GSP_FIRST   = 6'h08;
    localparam logic [5:0] DT_GSP_LAST    = 6'h0F;
    localparam logic [5:0] DT_VIDEO_MIN   = 6'h18;

    // bit n set: data type n is handled by this receiver
    localparam logic [63:0] DEFAULT_DT_MASK = 64'h00FF_3F1C_FF04_FF0F;

    typedef struct packed {
        logic open;
        logic crc_mark;
        logic sync_evt;
        logic data_evt;
    } frame_state_t;

endpackage

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
    import pkt_mon_pkg::*;
#(
    parameter int          DT_W         = 6,
    parameter logic [63:0] SUPPORTED_DT = DEFAULT_DT_MASK
) (
    input  logic [DT_W-1:0] dt,
    output logic            supported,
    output logic            is_fs,
    output logic            is_fe,
    output logic            is_gsp,
    output logic            is_video
);

    always_comb begin
        supported = SUPPORTED_DT[dt];
        is_fs     = (dt == DT_FRAME_START);
        is_fe     = (dt == DT_FRAME_END);
        is_gsp    = (dt >= DT_GSP_FIRST) && (dt <= DT_GSP_LAST);
        is_video  = (dt >= DT_VIDEO_MIN);
    end

endmodule

// File: rtl/vc_frame_track.sv
module vc_frame_track
    import pkt_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fs_hit,
    input  logic fe_hit,
    input  logic crc_hit,
    output logic frame_open,
    output logic sync_evt,
    output logic data_evt
);

    frame_state_t st_d, st_q;

    always_comb begin
        logic mark_now;
        st_d          = st_q;
        st_d.sync_evt = 1'b0;
        st_d.data_evt = 1'b0;
        // a failing packet that ends in this cycle belongs to the open frame
        mark_now = st_q.crc_mark | (crc_hit & st_q.open);
        if (fe_hit) begin
            if (!st_q.open) begin
                st_d.sync_evt = 1'b1;
            end else begin
                st_d.data_evt = mark_now;
            end
            st_d.open     = 1'b0;
            st_d.crc_mark = 1'b0;
        end else if (fs_hit) begin
            st_d.open     = 1'b1;
            st_d.crc_mark = 1'b0;
        end else begin
            st_d.crc_mark = mark_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_open = st_q.open;
    assign sync_evt   = st_q.sync_evt;
    assign data_evt   = st_q.data_evt;

endmodule

// File: rtl/hdr_capture.sv
module hdr_capture #(
    parameter int NUM_VC = 16,
    parameter int VC_W   = 4,
    parameter int DT_W   = 6,
    parameter int WC_W   = 16,
    parameter int CAP_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gsp_hit,
    input  logic                   video_hit,
    input  logic [VC_W-1:0]        vc,
    input  logic [DT_W-1:0]        dt,
    input  logic [WC_W-1:0]        wc,
    output logic [CAP_W-1:0]       gsp_word,
    output logic [NUM_VC*DT_W-1:0] video_dt
);

    localparam int VC_FIELD_W  = 2;
    localparam int VC_FIELD_LO = DT_W;
    localparam int PAY_LO      = DT_W + VC_FIELD_W;

    typedef struct packed {
        logic [CAP_W-1:0]             gsp;
        logic [NUM_VC-1:0][DT_W-1:0]  vdt;
    } cap_state_t;

    cap_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (gsp_hit) begin
            cs_d.gsp                               = '0;
            cs_d.gsp[DT_W-1:0]                     = dt;
            cs_d.gsp[VC_FIELD_LO +: VC_FIELD_W]    = vc[VC_FIELD_W-1:0];
            cs_d.gsp[PAY_LO +: WC_W]               = wc;
        end
        if (video_hit) begin
            cs_d.vdt[vc] = dt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign gsp_word = cs_q.gsp;
    assign video_dt = cs_q.vdt;

endmodule

// File: rtl/pkt_hdr_monitor.sv
module pkt_hdr_monitor
    import pkt_mon_pkg::*;
#(
    parameter int          NUM_VC       = 16,
    parameter int          DT_W         = 6,
    parameter int          WC_W         = 16,
    parameter int          CAP_W        = 32,
    parameter logic [63:0] SUPPORTED_DT = DEFAULT_DT_MASK,
    localparam int         VC_W         = $clog2(NUM_VC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_valid,
    input  logic [VC_W-1:0]        hdr_vc,
    input  logic [DT_W-1:0]        hdr_dt,
    input  logic [WC_W-1:0]        hdr_wc,
    input  logic                   pkt_end_valid,
    input  logic [VC_W-1:0]        pkt_end_vc,
    input  logic                   pkt_end_crc_bad,
    output logic [NUM_VC-1:0]      sync_err_evt,
    output logic [NUM_VC-1:0]      data_err_evt,
    output logic [NUM_VC-1:0]      dtype_err_evt,
    output logic [CAP_W-1:0]       gsp_word,
    output logic [NUM_VC*DT_W-1:0] vc_video_dt
);

    typedef struct packed {
        logic [NUM_VC-1:0] dtype_evt;
    } top_state_t;

    logic dt_ok, dt_fs, dt_fe, dt_gsp, dt_video;
    logic accept;
    logic [NUM_VC-1:0] fs_hit, fe_hit, crc_hit, frame_open;
    top_state_t ts_d, ts_q;

    pkt_hdr_decode #(
        .DT_W         (DT_W),
        .SUPPORTED_DT (SUPPORTED_DT)
    ) u_decode (
        .dt        (hdr_dt),
        .supported (dt_ok),
        .is_fs     (dt_fs),
        .is_fe     (dt_fe),
        .is_gsp    (dt_gsp),
        .is_video  (dt_video)
    );

    always_comb begin
        accept  = hdr_valid & dt_ok;
        fs_hit  = '0;
        fe_hit  = '0;
        crc_hit = '0;
        fs_hit[hdr_vc]      = accept & dt_fs;
        fe_hit[hdr_vc]      = accept & dt_fe;
        crc_hit[pkt_end_vc] = pkt_end_valid & pkt_end_crc_bad;
        ts_d                = '0;
        ts_d.dtype_evt[hdr_vc] = hdr_valid & ~dt_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    for (genvar ch = 0; ch < NUM_VC; ch++) begin : g_vc
        vc_frame_track u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .fs_hit     (fs_hit[ch]),
            .fe_hit     (fe_hit[ch]),
            .crc_hit    (crc_hit[ch]),
            .frame_open (frame_open[ch]),
            .sync_evt   (sync_err_evt[ch]),
            .data_evt   (data_err_evt[ch])
        );
    end

    hdr_capture #(
        .NUM_VC (NUM_VC),
        .VC_W   (VC_W),
        .DT_W   (DT_W),
        .WC_W   (WC_W),
        .CAP_W  (CAP_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .gsp_hit   (accept & dt_gsp),
        .video_hit (accept & dt_video),
        .vc        (hdr_vc),
        .dt        (hdr_dt),
        .wc        (hdr_wc),
        .gsp_word  (gsp_word),
        .video_dt  (vc_video_dt)
    );

    assign dtype_err_evt = ts_q.dtype_evt;

endmodule

// File: rtl/pkt_hdr_monitor_chk.sv
module pkt_hdr_monitor_chk #(
    parameter int          NUM_VC       = 16,
    parameter int          DT_W         = 6,
    parameter int          CAP_W        = 32,
    parameter logic [63:0] SUPPORTED_DT = 64'h0,
    parameter int          VC_W         = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hdr_valid,
    input logic [DT_W-1:0]        hdr_dt,
    input logic [NUM_VC-1:0]      sync_err_evt,
    input logic [NUM_VC-1:0]      data_err_evt,
    input logic [NUM_VC-1:0]      dtype_err_evt,
    input logic [CAP_W-1:0]       gsp_word,
    input logic [NUM_VC*DT_W-1:0] vc_video_dt
);

    logic hdr_fe, hdr_bad, hdr_gsp, hdr_vid;
    assign hdr_fe  = hdr_valid && (hdr_dt == 6'h01);
    assign hdr_bad = hdr_valid && !SUPPORTED_DT[hdr_dt];
    assign hdr_gsp = hdr_valid && (hdr_dt >= 6'h08) && (hdr_dt <= 6'h0F);
    assign hdr_vid = hdr_valid && (hdr_dt >= 6'h18);

    assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_err_evt, data_err_evt, dtype_err_evt}));

    assert_sync_after_fe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_evt != '0) |-> $past(hdr_fe));

    assert_data_after_fe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_err_evt != '0) |-> $past(hdr_fe));

    assert_dtype_after_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dtype_err_evt != '0) |-> $past(hdr_bad));

    assert_gsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hdr_gsp) |-> $stable(gsp_word));

    assert_vdt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hdr_vid) |-> $stable(vc_video_dt));

endmodule

bind pkt_hdr_monitor pkt_hdr_monitor_chk #(
    .NUM_VC       (NUM_VC),
    .DT_W         (DT_W),
    .CAP_W        (CAP_W),
    .SUPPORTED_DT (SUPPORTED_DT),
    .VC_W         (VC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_valid     (hdr_valid),
    .hdr_dt        (hdr_dt),
    .sync_err_evt  (sync_err_evt),
    .data_err_evt  (data_err_evt),
    .dtype_err_evt (dtype_err_evt),
    .gsp_word      (gsp_word),
    .vc_video_dt   (vc_video_dt)
);

// File: tb/tb_pkt_hdr_monitor.sv
module tb_pkt_hdr_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [3:0]  hdr_vc = '0;
    logic [5:0]  hdr_dt = '0;
    logic [15:0] hdr_wc = '0;
    logic        pkt_end_valid = 1'b0;
    logic [3:0]  pkt_end_vc = '0;
    logic        pkt_end_crc_bad = 1'b0;
    logic [15:0] sync_err_evt, data_err_evt, dtype_err_evt;
    logic [31:0] gsp_word;
    logic [95:0] vc_video_dt;

    int n_chk = 0;
    int n_fail = 0;
    logic [95:0] exp_vdt = '0;

    always #10 clk = ~clk;

    pkt_hdr_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_vc(hdr_vc), .hdr_dt(hdr_dt), .hdr_wc(hdr_wc),
        .pkt_end_valid(pkt_end_valid), .pkt_end_vc(pkt_end_vc),
        .pkt_end_crc_bad(pkt_end_crc_bad),
        .sync_err_evt(sync_err_evt), .data_err_evt(data_err_evt),
        .dtype_err_evt(dtype_err_evt), .gsp_word(gsp_word),
        .vc_video_dt(vc_video_dt)
    );

    // supported data types as listed in R7
    function automatic bit dt_supported(input logic [5:0] dt);
        return (dt <= 6'h03) || (dt >= 6'h08 && dt <= 6'h0F) || (dt == 6'h12) ||
               (dt >= 6'h18 && dt <= 6'h1F) || (dt >= 6'h22 && dt <= 6'h24) ||
               (dt >= 6'h28 && dt <= 6'h2D) || (dt >= 6'h30 && dt <= 6'h37);
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the negedge after the sampling edge
    task automatic step(input logic hv, input logic [3:0] vc, input logic [5:0] dt,
                        input logic [15:0] wc, input logic pv, input logic [3:0] pvc,
                        input logic bad);
        @(negedge clk);
        hdr_valid = hv; hdr_vc = vc; hdr_dt = dt; hdr_wc = wc;
        pkt_end_valid = pv; pkt_end_vc = pvc; pkt_end_crc_bad = bad;
        @(negedge clk);
        hdr_valid = 1'b0; pkt_end_valid = 1'b0; pkt_end_crc_bad = 1'b0;
        if (hv && dt_supported(dt) && dt >= 6'h18) exp_vdt[vc*6 +: 6] = dt;
    endtask

    task automatic hdr(input logic [3:0] vc, input logic [5:0] dt, input logic [15:0] wc);
        step(1'b1, vc, dt, wc, 1'b0, 4'd0, 1'b0);
    endtask

    task automatic pend(input logic [3:0] vc, input logic bad);
        step(1'b0, 4'd0, 6'd0, 16'd0, 1'b1, vc, bad);
    endtask

    function automatic logic [15:0] bitv(input int ch);
        return 16'h1 << ch;
    endfunction

    task automatic t_reset;
        chk("R1 sync", {80'd0, sync_err_evt}, 96'd0);
        chk("R1 data", {80'd0, data_err_evt | dtype_err_evt}, 96'd0);
        chk("R1 gsp", {64'd0, gsp_word}, 96'd0);
        chk("R1 vdt", vc_video_dt, 96'd0);
    endtask

    task automatic t_sync;
        hdr(4'd3, 6'h01, 16'd0);
        chk("R2 fe without fs", {80'd0, sync_err_evt}, {80'd0, bitv(3)});
        chk("R2 no data evt", {80'd0, data_err_evt}, 96'd0);
        hdr(4'd3, 6'h00, 16'd0);
        chk("R11 pulse cleared", {80'd0, sync_err_evt}, 96'd0);
        hdr(4'd3, 6'h01, 16'd0);
        chk("R2 paired fe", {80'd0, sync_err_evt}, 96'd0);
        hdr(4'd3, 6'h01, 16'd0);
        chk("R2 second fe", {80'd0, sync_err_evt}, {80'd0, bitv(3)});
    endtask

    task automatic t_crc;
        hdr(4'd5, 6'h00, 16'd0);
        hdr(4'd5, 6'h2A, 16'd640);
        pend(4'd5, 1'b1);
        hdr(4'd5, 6'h2A, 16'd640);
        pend(4'd5, 1'b0);
        hdr(4'd5, 6'h01, 16'd0);
        chk("R3 crc in frame", {80'd0, data_err_evt}, {80'd0, bitv(5)});
        hdr(4'd5, 6'h00, 16'd0);
        pend(4'd5, 1'b0);
        hdr(4'd5, 6'h01, 16'd0);
        chk("R3 mark cleared", {80'd0, data_err_evt}, 96'd0);
    endtask

    task automatic t_outside;
        pend(4'd6, 1'b1);
        hdr(4'd6, 6'h00, 16'd0);
        hdr(4'd6, 6'h01, 16'd0);
        chk("R4 crc outside frame", {80'd0, data_err_evt}, 96'd0);
    endtask

    task automatic t_restart;
        hdr(4'd7, 6'h00, 16'd0);
        pend(4'd7, 1'b1);
        hdr(4'd7, 6'h00, 16'd0);
        chk("R5 restart no event", {48'd0, sync_err_evt, data_err_evt, dtype_err_evt}, 96'd0);
        hdr(4'd7, 6'h01, 16'd0);
        chk("R5 restart clears mark", {64'd0, sync_err_evt, data_err_evt}, 96'd0);
    endtask

    task automatic t_indep;
        hdr(4'd1, 6'h00, 16'd0);
        hdr(4'd2, 6'h00, 16'd0);
        pend(4'd2, 1'b1);
        hdr(4'd1, 6'h01, 16'd0);
        chk("R6 ch1 clean", {80'd0, data_err_evt}, 96'd0);
        hdr(4'd2, 6'h01, 16'd0);
        chk("R6 ch2 error", {80'd0, data_err_evt}, {80'd0, bitv(2)});
        hdr(4'd1, 6'h01, 16'd0);
        chk("R6 ch1 sync only", {64'd0, sync_err_evt, data_err_evt}, {64'd0, bitv(1), 16'd0});
    endtask

    task automatic t_dtype;
        logic [31:0] g;
        hdr(4'd9, 6'h05, 16'h5555);
        chk("R7 dt 0x05", {80'd0, dtype_err_evt}, {80'd0, bitv(9)});
        g = gsp_word;
        hdr(4'd9, 6'h3F, 16'h1111);
        chk("R7 dt 0x3F", {80'd0, dtype_err_evt}, {80'd0, bitv(9)});
        chk("R7 vdt untouched", vc_video_dt, exp_vdt);
        chk("R7 gsp untouched", {64'd0, gsp_word}, {64'd0, g});
        hdr(4'd9, 6'h20, 16'd0);
        chk("R7 dt 0x20", {80'd0, dtype_err_evt}, {80'd0, bitv(9)});
        hdr(4'd9, 6'h2C, 16'd0);
        chk("R7 supported no event", {80'd0, dtype_err_evt}, 96'd0);
    endtask

    task automatic t_gsp;
        hdr(4'd2, 6'h0A, 16'hBEEF);
        chk("R8 capture ch2", {64'd0, gsp_word}, {64'd0, 32'h00BE_EF8A});
        hdr(4'd13, 6'h0F, 16'h1234);
        chk("R8 capture ch13", {64'd0, gsp_word}, {64'd0, 32'h0012_344F});
        hdr(4'd13, 6'h00, 16'hFFFF);
        chk("R8 hold on fs", {64'd0, gsp_word}, {64'd0, 32'h0012_344F});
    endtask

    task automatic t_vdt;
        hdr(4'd4, 6'h2B, 16'd10);
        chk("R9 load 0x2B", vc_video_dt, exp_vdt);
        chk("R9 slot ch4", {90'd0, vc_video_dt[29:24]}, {90'd0, 6'h2B});
        hdr(4'd4, 6'h12, 16'd10);
        chk("R9 0x12 no load", {90'd0, vc_video_dt[29:24]}, {90'd0, 6'h2B});
        hdr(4'd4, 6'h18, 16'd10);
        chk("R9 load 0x18", vc_video_dt, exp_vdt);
    endtask

    task automatic t_collide;
        hdr(4'd10, 6'h00, 16'd0);
        step(1'b1, 4'd10, 6'h01, 16'd0, 1'b1, 4'd10, 1'b1);
        chk("R10 crc with fe", {80'd0, data_err_evt}, {80'd0, bitv(10)});
        hdr(4'd11, 6'h00, 16'd0);
        step(1'b1, 4'd11, 6'h00, 16'd0, 1'b1, 4'd11, 1'b1);
        hdr(4'd11, 6'h01, 16'd0);
        chk("R10 crc with fs open", {80'd0, data_err_evt}, 96'd0);
        step(1'b1, 4'd12, 6'h00, 16'd0, 1'b1, 4'd12, 1'b1);
        hdr(4'd12, 6'h01, 16'd0);
        chk("R10 crc with fs closed", {80'd0, data_err_evt}, 96'd0);
    endtask

    task automatic t_pulse;
        hdr(4'd14, 6'h01, 16'd0);
        chk("R11 pulse present", {80'd0, sync_err_evt}, {80'd0, bitv(14)});
        @(negedge clk);
        chk("R11 pulse one cycle", {48'd0, sync_err_evt, data_err_evt, dtype_err_evt}, 96'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_sync;
        t_crc;
        t_outside;
        t_restart;
        t_indep;
        t_dtype;
        t_gsp;
        t_vdt;
        t_collide;
        t_pulse;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule